// File: doc/BRIEF.md
# Streaming Frame Integrity Checker

This block sits on the receive side of a MAC client port and watches every frame that arrives on a 256-bit streaming sink. Each frame carries a 32-bit sequence number in its first four bytes and a 16-bit byte length in the next two. After those six bytes comes a payload that follows a known test pattern. The checker confirms that the sequence number continues from the previous frame. It confirms that the length field equals the number of bytes actually delivered, and that every payload byte matches the configured pattern.

Results are kept in saturating counters that software reads over a 32-bit register port. The counters cover good frames, bad frames, total bytes, and each error class. One write to the control word sets the payload pattern and can also zero all counters. The checker never stalls the data path. CRC and preamble handling take place upstream.

Top module: `pkt_integrity_mon`

## Requirements
- R1: After reset, every counter reads 0 and the control word reads 0, so the payload pattern starts in incrementing mode.
- R2: Byte k of a beat is carried on rxData[255-8k -: 8]. Bytes 0-3 of a frame hold the sequence number, most significant byte first. Bytes 4-5 hold the length field, most significant byte first.
- R3: The first frame after reset is accepted with any sequence number. Every later start-of-packet must carry the previous number plus 1. A mismatch adds 1 to the sequence-error counter (address 4) on that start beat. In either case the expected value becomes the received number plus 1.
- R4: The measured length is 32 bytes for each beat of the frame, minus rxEmpty on the end beat. If it differs from the length field, the length-error counter (address 5) adds 1.
- R5: Frame byte k, for k ≥ 6, must equal (k-6) mod 256 when control bit 0 is 0, or control bits 15:8 when control bit 0 is 1. Bytes beyond the valid count of the end beat are not checked. Any mismatch adds 1 to the payload-error counter (address 6), once per frame.
- R6: At end-of-packet, a frame with no sequence, length or payload error adds 1 to the good counter (address 1). Any other frame adds 1 to the bad counter (address 2). Every completed frame adds its measured length to the byte counter (address 3).
- R7: A start-of-packet that arrives while a frame is open adds 1 to the framing-error counter (address 7). The open frame is dropped without a good/bad verdict or a byte count, and the new frame is parsed from its start. Beats with rxValid low are ignored, and so are valid beats without start-of-packet outside a frame.
- R8: Every counter saturates at 2^CNT_W-1 instead of wrapping.
- R9: A write to address 0 stores bit 0 (pattern mode) and bits 15:8 (constant byte). If bit 31 of the written data is 1, all counters are zero in the next cycle. Bit 31 always reads 0.
- R10: csrReadData shows the addressed register combinationally, zero-extended. Addresses 8 and above read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxData | input | 256 | Beat data, byte 0 in the top bits |
| rxValid | input | 1 | Beat is valid |
| rxSop | input | 1 | First beat of a frame |
| rxEop | input | 1 | Last beat of a frame |
| rxEmpty | input | 5 | Unused bytes at the end of the last beat |
| csrAddr | input | 4 | Register word address |
| csrWrite | input | 1 | Register write strobe |
| csrWriteData | input | 32 | Register write data |
| csrReadData | output | 32 | Register read data |

## Verification
The following are checked by embedded properties on every cycle:
- Counters never decrease except when cleared, and they are zero right after a clear.
- An end beat closes the frame and a lone start beat opens one.
- The expected sequence value always becomes the last received number plus 1.
- Control-word writes land in the pattern registers.

The bench scenarios are what show the verdicts:
- good versus bad;
- per-class error counts;
- byte totals;
- dropped frames on a repeated start;
- ignored lane bytes;
- the saturation values.

These are compared against a bench model that tracks frames, sequence numbers and patterns independently.

// File: rtl/pim_pkg.sv
package pim_pkg;
  localparam int DATA_W     = 256;
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int EMPTY_W    = $clog2(BEAT_BYTES);
  localparam int BYTES_W    = EMPTY_W + 1;
  localparam int MEAS_W     = 17;
  localparam int SEQ_W      = 32;
  localparam int LEN_W      = 16;
  localparam int HDR_BYTES  = 6;
  localparam int NUM_EVT    = 6;

  // Event order used for the counter array: good, bad, seq, len, payload, framing
  typedef struct packed {
    logic              frameErr;
    logic              payErr;
    logic              lenErr;
    logic              seqErr;
    logic              bad;
    logic              good;
    logic [MEAS_W-1:0] frameBytes;
  } evStrobe_t;
endpackage

// File: rtl/pim_datapath.sv
module pim_datapath
  import pim_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [DATA_W-1:0]               beatData,
  input  logic                            beatEop,
  input  logic [EMPTY_W-1:0]              beatEmpty,
  input  logic [MEAS_W-1:0]               baseOff,
  input  logic                            patConst,
  input  logic [7:0]                      patByte,
  output logic                            beatMismatch,
  output logic [BYTES_W-1:0]              beatBytes,
  input  evStrobe_t                       strb,
  input  logic                            clearCnt,
  output logic [NUM_EVT-1:0][CNT_W-1:0]   evCnt,
  output logic [CNT_W-1:0]                byteCnt
);
  localparam int SUM_W = ((CNT_W > MEAS_W) ? CNT_W : MEAS_W) + 1;
  localparam logic [SUM_W-1:0] CNT_MAX = (SUM_W'(1) << CNT_W) - SUM_W'(1);

  logic [BYTES_W-1:0]    validBytes;
  logic [BEAT_BYTES-1:0] laneBad;

  assign validBytes = BYTES_W'(BEAT_BYTES) - BYTES_W'(beatEmpty);
  assign beatBytes  = beatEop ? validBytes : BYTES_W'(BEAT_BYTES);

  for (genvar j = 0; j < BEAT_BYTES; j++) begin : g_lane
    logic [MEAS_W-1:0] off;
    logic [7:0]        gotByte;
    logic [7:0]        expByte;
    logic              laneOn;
    assign off     = baseOff + MEAS_W'(j);
    assign gotByte = beatData[DATA_W-1-8*j -: 8];
    assign expByte = patConst ? patByte : 8'(off - MEAS_W'(HDR_BYTES));
    assign laneOn  = (!beatEop || (BYTES_W'(j) < validBytes)) && (off >= MEAS_W'(HDR_BYTES));
    assign laneBad[j] = laneOn && (gotByte != expByte);
  end
  assign beatMismatch = |laneBad;

  logic [NUM_EVT-1:0] evHit;
  assign evHit = {strb.frameErr, strb.payErr, strb.lenErr, strb.seqErr, strb.bad, strb.good};

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n || clearCnt)                             evCnt[i] <= '0;
      else if (evHit[i] && (SUM_W'(evCnt[i]) != CNT_MAX)) evCnt[i] <= evCnt[i] + CNT_W'(1);
    end
    // R8: no wrap, counters only move up between clears
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !clearCnt |=> evCnt[i] >= $past(evCnt[i]));
    p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clearCnt |=> evCnt[i] == '0);
  end

  logic [SUM_W-1:0] byteSum;
  assign byteSum = SUM_W'(byteCnt) + SUM_W'(strb.frameBytes);

  always_ff @(posedge clk) begin
    if (!rst_n || clearCnt) byteCnt <= '0;
    else if (strb.good || strb.bad)
      byteCnt <= (byteSum > CNT_MAX) ? CNT_W'(CNT_MAX) : CNT_W'(byteSum);
  end

  p_bytes_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clearCnt |=> byteCnt >= $past(byteCnt));
endmodule

// File: rtl/pim_ctrl.sv
module pim_ctrl
  import pim_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rxValid,
  input  logic               rxSop,
  input  logic               rxEop,
  input  logic [SEQ_W-1:0]   seqField,
  input  logic [LEN_W-1:0]   lenField,
  input  logic               beatMismatch,
  input  logic [BYTES_W-1:0] beatBytes,
  output logic [MEAS_W-1:0]  baseOff,
  output evStrobe_t          strb
);
  logic              inFrame;
  logic [MEAS_W-1:0] byteSoFar;
  logic [LEN_W-1:0]  lenReg;
  logic              seqBadReg;
  logic              payBadReg;
  logic [SEQ_W-1:0]  expSeq;
  logic              seqValid;

  logic              sopBeat, takeBeat, endBeat;
  logic              seqMiss, frameSeqBad, framePayBad, lenMiss;
  logic [LEN_W-1:0]  frameLen;
  logic [MEAS_W-1:0] measured;

  always_comb begin
    sopBeat     = rxValid && rxSop;
    takeBeat    = rxValid && (rxSop || inFrame);
    endBeat     = takeBeat && rxEop;
    baseOff     = rxSop ? '0 : byteSoFar;
    seqMiss     = sopBeat && seqValid && (seqField != expSeq);
    frameSeqBad = rxSop ? seqMiss : seqBadReg;
    framePayBad = (!rxSop && payBadReg) || beatMismatch;
    frameLen    = rxSop ? lenField : lenReg;
    measured    = baseOff + MEAS_W'(beatBytes);
    lenMiss     = measured != MEAS_W'(frameLen);

    strb            = '0;
    strb.frameErr   = sopBeat && inFrame;
    strb.seqErr     = seqMiss;
    strb.lenErr     = endBeat && lenMiss;
    strb.payErr     = endBeat && framePayBad;
    strb.bad        = endBeat && (frameSeqBad || lenMiss || framePayBad);
    strb.good       = endBeat && !(frameSeqBad || lenMiss || framePayBad);
    strb.frameBytes = measured;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inFrame   <= 1'b0;
      byteSoFar <= '0;
      lenReg    <= '0;
      seqBadReg <= 1'b0;
      payBadReg <= 1'b0;
      expSeq    <= '0;
      seqValid  <= 1'b0;
    end else begin
      if (takeBeat) begin
        inFrame   <= !rxEop;
        byteSoFar <= measured;
        lenReg    <= frameLen;
        seqBadReg <= frameSeqBad;
        payBadReg <= framePayBad;
      end
      if (sopBeat) begin
        expSeq   <= seqField + SEQ_W'(1);
        seqValid <= 1'b1;
      end
    end
  end

  p_eop_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (takeBeat && rxEop) |=> !inFrame);
  p_sop_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sopBeat && !rxEop) |=> inFrame);
  p_seq_resync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sopBeat |=> (seqValid && expSeq == $past(seqField) + SEQ_W'(1)));
endmodule

// File: rtl/pkt_integrity_mon.sv
module pkt_integrity_mon
  import pim_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  rxData,
  input  logic               rxValid,
  input  logic               rxSop,
  input  logic               rxEop,
  input  logic [EMPTY_W-1:0] rxEmpty,
  input  logic [ADDR_W-1:0]  csrAddr,
  input  logic               csrWrite,
  input  logic [31:0]        csrWriteData,
  output logic [31:0]        csrReadData
);
  logic                          patConst;
  logic [7:0]                    patByte;
  logic                          clearCnt;
  logic                          beatMismatch;
  logic [BYTES_W-1:0]            beatBytes;
  logic [MEAS_W-1:0]             baseOff;
  evStrobe_t                     strb;
  logic [NUM_EVT-1:0][CNT_W-1:0] evCnt;
  logic [CNT_W-1:0]              byteCnt;
  logic                          ctrlWr;
  logic                          unusedWdata;

  assign ctrlWr      = csrWrite && (csrAddr == '0);
  assign clearCnt    = ctrlWr && csrWriteData[31];
  assign unusedWdata = ^{csrWriteData[30:16], csrWriteData[7:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      patConst <= 1'b0;
      patByte  <= '0;
    end else if (ctrlWr) begin
      patConst <= csrWriteData[0];
      patByte  <= csrWriteData[15:8];
    end
  end

  p_cfg_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlWr |=> (patConst == $past(csrWriteData[0]) && patByte == $past(csrWriteData[15:8])));

  pim_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rxValid(rxValid), .rxSop(rxSop), .rxEop(rxEop),
    .seqField(rxData[DATA_W-1 -: SEQ_W]),
    .lenField(rxData[DATA_W-1-SEQ_W -: LEN_W]),
    .beatMismatch(beatMismatch), .beatBytes(beatBytes),
    .baseOff(baseOff), .strb(strb)
  );

  pim_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .beatData(rxData), .beatEop(rxEop), .beatEmpty(rxEmpty),
    .baseOff(baseOff), .patConst(patConst), .patByte(patByte),
    .beatMismatch(beatMismatch), .beatBytes(beatBytes),
    .strb(strb), .clearCnt(clearCnt),
    .evCnt(evCnt), .byteCnt(byteCnt)
  );

  always_comb begin
    case (csrAddr)
      ADDR_W'(0): csrReadData = {16'b0, patByte, 7'b0, patConst};
      ADDR_W'(1): csrReadData = 32'(evCnt[0]);
      ADDR_W'(2): csrReadData = 32'(evCnt[1]);
      ADDR_W'(3): csrReadData = 32'(byteCnt);
      ADDR_W'(4): csrReadData = 32'(evCnt[2]);
      ADDR_W'(5): csrReadData = 32'(evCnt[3]);
      ADDR_W'(6): csrReadData = 32'(evCnt[4]);
      ADDR_W'(7): csrReadData = 32'(evCnt[5]);
      default:    csrReadData = '0;
    endcase
  end
endmodule

// File: tb/sim_pkt_integrity_mon.sv
module sim_pkt_integrity_mon;
  localparam int CW   = 12;
  localparam int CMAX = (1 << CW) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [255:0] rxData;
  logic         rxValid, rxSop, rxEop;
  logic [4:0]   rxEmpty;
  logic [3:0]   csrAddr;
  logic         csrWrite;
  logic [31:0]  csrWriteData;
  logic [31:0]  csrReadData;

  always #2 clk = ~clk;

  pkt_integrity_mon #(.CNT_W(CW), .ADDR_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .rxData(rxData), .rxValid(rxValid),
    .rxSop(rxSop), .rxEop(rxEop), .rxEmpty(rxEmpty), .csrAddr(csrAddr),
    .csrWrite(csrWrite), .csrWriteData(csrWriteData), .csrReadData(csrReadData)
  );

  int nChecks = 0;
  int nFails  = 0;
  int mGood = 0, mBad = 0, mBytes = 0, mSeq = 0, mLen = 0, mPay = 0, mFrm = 0;
  bit mOpen = 0, mSeqValid = 0;
  logic [31:0] mExpSeq = '0;
  bit   cfgConst = 0;
  logic [7:0] cfgByte = '0;
  logic [7:0] fb [0:511];

  function automatic int sat(int cur, int inc);
    return (cur + inc > CMAX) ? CMAX : cur + inc;
  endfunction

  function automatic logic [7:0] expPat(int k);
    return cfgConst ? cfgByte : 8'(k - 6);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic readCheck(int a, int exp, string tag);
    @(negedge clk);
    csrAddr = 4'(a);
    #1;
    check(tag, csrReadData, 32'(exp));
  endtask

  task automatic checkAll(string ph);
    readCheck(1, mGood,  {ph, " R6 good"});
    readCheck(2, mBad,   {ph, " R6 bad"});
    readCheck(3, mBytes, {ph, " R6 bytes"});
    readCheck(4, mSeq,   {ph, " R3 seq"});
    readCheck(5, mLen,   {ph, " R4 len"});
    readCheck(6, mPay,   {ph, " R5 payload"});
    readCheck(7, mFrm,   {ph, " R7 framing"});
  endtask

  task automatic csrWr(logic [31:0] d);
    @(negedge clk);
    csrAddr = 4'd0; csrWriteData = d; csrWrite = 1'b1;
    @(negedge clk);
    csrWrite = 1'b0;
    cfgConst = d[0];
    cfgByte  = d[15:8];
    if (d[31]) begin
      mGood = 0; mBad = 0; mBytes = 0; mSeq = 0; mLen = 0; mPay = 0; mFrm = 0;
    end
  endtask

  task automatic buildFrame(logic [31:0] seq, int lenF, int n, int corrupt);
    fb[0] = seq[31:24]; fb[1] = seq[23:16]; fb[2] = seq[15:8]; fb[3] = seq[7:0];
    fb[4] = 8'(lenF >> 8); fb[5] = 8'(lenF);
    for (int k = 6; k < n; k++) fb[k] = expPat(k);
    if (corrupt >= 6 && corrupt < n) fb[corrupt] = fb[corrupt] ^ 8'h5A;
  endtask

  task automatic driveFrame(int n, bit withEop);
    int nb;
    nb = (n + 31) / 32;
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      rxValid = 1'b1;
      rxSop   = (b == 0);
      rxEop   = withEop && (b == nb - 1);
      rxEmpty = rxEop ? 5'(nb * 32 - n) : 5'd0;
      for (int j = 0; j < 32; j++)
        rxData[255-8*j -: 8] = (b*32 + j < n) ? fb[b*32 + j] : 8'($urandom);
    end
    @(negedge clk);
    rxValid = 1'b0; rxSop = 1'b0; rxEop = 1'b0;
    rxData  = {8{$urandom}};
  endtask

  task automatic modelSop(logic [31:0] seq);
    if (mOpen) mFrm = sat(mFrm, 1);
    if (mSeqValid && seq != mExpSeq) mSeq = sat(mSeq, 1);
    mOpen = 1;
  endtask

  task automatic modelEnd(logic [31:0] seq, int lenF, int n);
    bit payBad, lenBad, seqBad;
    seqBad = mSeqValid && seq != mExpSeq;
    mExpSeq = seq + 1;
    mSeqValid = 1;
    payBad = 0;
    for (int k = 6; k < n; k++) if (fb[k] != expPat(k)) payBad = 1;
    lenBad = (lenF != n);
    if (lenBad) mLen = sat(mLen, 1);
    if (payBad) mPay = sat(mPay, 1);
    if (seqBad || lenBad || payBad) mBad = sat(mBad, 1);
    else mGood = sat(mGood, 1);
    mBytes = sat(mBytes, n);
    mOpen = 0;
  endtask

  task automatic frame(logic [31:0] seq, int lenF, int n, int corrupt);
    buildFrame(seq, lenF, n, corrupt);
    modelSop(seq);
    driveFrame(n, 1'b1);
    modelEnd(seq, lenF, n);
  endtask

  task automatic partial(logic [31:0] seq, int n);
    buildFrame(seq, n, n, -1);
    modelSop(seq);
    mExpSeq = seq + 1;
    mSeqValid = 1;
    driveFrame(n, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; rxData = '0; rxValid = 0; rxSop = 0; rxEop = 0; rxEmpty = '0;
    csrAddr = '0; csrWrite = 0; csrWriteData = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R10 unmapped read
    readCheck(0, 0, "R1 ctrl after reset");
    checkAll("R1 reset");
    readCheck(9, 0, "R10 unmapped address");

    // R2/R3 first frame accepted with any number, incrementing pattern
    frame(32'h0102_0304, 40, 40, -1);
    checkAll("R2 first frame");
    frame(32'h0102_0305, 64, 64, -1);   // R4 exact beats, empty 0
    frame(32'h0102_0306, 33, 33, -1);   // R4 empty 31
    checkAll("R4 boundaries");
    frame(32'd500, 50, 50, -1);          // R3 jump
    frame(32'd501, 50, 50, -1);          // R3 resync
    checkAll("R3 jump resync");
    frame(32'd502, 50, 49, -1);          // R4 mismatch
    frame(32'd503, 80, 80, 6);           // R5 first payload byte
    frame(32'd504, 80, 80, 79);          // R5 last byte
    checkAll("R4 R5 errors");

    // R9 config write, R5 constant mode
    csrWr(32'h0000_A501);
    readCheck(0, 32'h0000_A501, "R9 ctrl readback");
    frame(32'd505, 70, 70, -1);
    frame(32'd506, 70, 70, 30);
    checkAll("R5 const mode");

    // R7 repeated start drops open frame
    partial(32'd507, 70);
    frame(32'd508, 45, 45, -1);
    checkAll("R7 framing");
    // R7 stray beat outside a frame is ignored
    @(negedge clk);
    rxValid = 1; rxSop = 0; rxEop = 1; rxEmpty = 5'd3; rxData = {8{$urandom}};
    @(negedge clk);
    rxValid = 0; rxEop = 0;
    checkAll("R7 stray beat");

    // random phase
    for (int i = 0; i < 80; i++) begin
      int n, lenF, cor;
      logic [31:0] sq;
      if (i == 40) csrWr(32'h0000_3C00);
      n    = 6 + int'($urandom_range(0, 294));
      sq   = ($urandom_range(0, 9) == 0) ? $urandom : mExpSeq;
      lenF = ($urandom_range(0, 6) == 0) ? n + int'($urandom_range(1, 3)) : n;
      cor  = ($urandom_range(0, 6) == 0) ? int'($urandom_range(6, n)) : -1;
      if ($urandom_range(0, 19) == 0) partial($urandom, 40);
      frame(sq, lenF, n, cor);
      repeat ($urandom_range(0, 3)) @(negedge clk);
      if (i % 20 == 19) checkAll("random");
    end

    // R9 clear
    csrWr(32'h8000_0000);
    readCheck(0, 0, "R9 clear bit reads 0");
    checkAll("R9 cleared");

    // R8 saturation
    for (int i = 0; i < CMAX + 5; i++) frame(mExpSeq, 8, 8, -1);
    readCheck(1, CMAX, "R8 good saturates");
    readCheck(3, CMAX, "R8 bytes saturate");
    checkAll("R8 saturation");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule